// File: doc/BRIEF.md
# Write-Back Port Conflict Scheduler

This block controls issue and stage occupancy for a five-stage in-order pipeline model. The stages, in order, are fetch, decode with register read, execute, memory access and write-back. Two instruction classes pass through it: loads, and register-type operations. Instruction tags arrive on a valid/ready handshake. The block records which tag sits in each stage, and it drives a single register-file write strobe carrying the tag that retires. It does no datapath work.

A load needs all five stages before it writes. In the short policy, a register-type operation skips memory access and writes one stage earlier. As a result, a register-type operation issued right behind a load would write in the same cycle as that load. The scheduler offers two ways to prevent this collision.

- **Bubble policy:** issue is withheld for one cycle.
- **Padded policy:** every register-type operation takes the full five stages, with a no-op memory stage.

The policy input takes effect only while the pipeline is empty. Free-running counters report cycles, retirements and bubbles, so throughput can be measured from outside.

Top module: `wb_port_sched`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every bit of `stage_valid` is 0. In those cycles `wb_en` is 0, `wb_collide_err` is 0, all three counters read 0 and `in_ready` is 1.
- R2: A tag accepted at a clock edge (`in_valid` and `in_ready` both 1) occupies stage index 0 in the next cycle. It then advances one stage index per cycle and keeps its tag. The stage indices are 0 fetch, 1 decode, 2 execute, 3 memory and 4 write-back. Stage s occupies bits s of `stage_valid` and bits [s*TAG_W +: TAG_W] of `stage_tags`.
- R3: A load (`in_is_load`=1) asserts `wb_en`, with `wb_tag` equal to its tag, in the cycle it occupies stage index 4. That is five cycles after the cycle in which it was accepted.
- R4: Under the bubble policy (`mode_i`=0), a register-type operation (`in_is_load`=0) asserts `wb_en` with its tag while it occupies stage index 3. It then leaves the pipeline and never occupies stage index 4.
- R5: Under the bubble policy, `in_ready` is 0 in any cycle where stage index 0 holds a load and the presented class is register-type. While `in_valid` is 1 no instruction issues in that cycle. The held instruction is accepted in the next cycle.
- R6: Under the padded policy (`mode_i`=1), a register-type operation occupies stage index 3 as a no-op and asserts `wb_en` in stage index 4. Under this policy `in_ready` is never 0.
- R7: At most one retirement happens per cycle. `wb_collide_err` is a sticky flag that would set if two retirements coincided, and it stays 0 under both policies.
- R8: `mode_i` is taken only in cycles where every stage is empty. Changing it while any stage is occupied has no effect. The policy taken last keeps governing until the pipeline drains.
- R9: `cnt_cycles` increments once per clock after reset. `cnt_retired` increments once for each cycle with `wb_en`=1. `cnt_bubbles` increments once for each cycle with `in_valid`=1 and `in_ready`=0.
- R10: Under the padded policy with a continuous supply, one instruction retires every cycle after a five-cycle fill. Under the bubble policy, a stream of alternating load and register-type instructions costs exactly one bubble per pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_i | input | 1 | Collision policy: 0 bubble, 1 padded; taken while pipeline empty |
| in_valid | input | 1 | An instruction is presented |
| in_ready | output | 1 | The presented instruction is accepted at the next edge |
| in_is_load | input | 1 | Class of the presented instruction: 1 load, 0 register-type |
| in_tag | input | TAG_W | Tag of the presented instruction |
| wb_en | output | 1 | Register-file write strobe |
| wb_tag | output | TAG_W | Tag of the retiring instruction |
| wb_collide_err | output | 1 | Sticky flag for two coinciding retirements |
| stage_valid | output | 5 | Occupancy per stage index |
| stage_tags | output | 5*TAG_W | Tag per stage index, packed |
| cnt_cycles | output | CNT_W | Cycles since reset |
| cnt_retired | output | CNT_W | Retirements since reset |
| cnt_bubbles | output | CNT_W | Withheld-issue cycles since reset |

## Verification
Directed sequences place a register-type operation directly behind a load under each policy, which separates the bubble case from the padded case. They also flip the policy input while instructions are in flight, to show the setting is ignored until the pipeline drains. A fully occupied padded stream and an alternating load/register-type stream under the bubble policy give the two throughput extremes. A long constrained-random phase mixes classes, idle gaps, held instructions and policy changes. In every cycle it compares the write strobe, the stage map and the counters against a model kept in the bench.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
  localparam int NUM_STG = 5;
  localparam int STG_IF  = 0;
  localparam int STG_MEM = 3;
  localparam int STG_WB  = 4;

  typedef enum logic {
    POL_BUBBLE = 1'b0,
    POL_PADDED = 1'b1
  } wb_policy_e;
endpackage

// File: rtl/wbs_issue_ctrl.sv
module wbs_issue_ctrl
  import wbs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic pipe_empty,
  input  logic s0_vld,
  input  logic s0_load,
  input  logic in_valid,
  input  logic in_is_load,
  output logic in_ready,
  output logic issue_fire,
  output logic issue_short,
  output logic bubble
);
  wb_policy_e pol_q;
  wb_policy_e pol_d;

  // policy input only counts while nothing is in flight
  always_comb begin
    pol_d       = pipe_empty ? wb_policy_e'(mode_i) : pol_q;
    in_ready    = !((pol_d == POL_BUBBLE) && s0_vld && s0_load && !in_is_load);
    issue_fire  = in_valid && in_ready;
    bubble      = in_valid && !in_ready;
    issue_short = !in_is_load && (pol_d == POL_BUBBLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pol_q <= POL_BUBBLE;
    else        pol_q <= pol_d;
  end

  // R5: a withheld slot is followed by a free one
  a_r5_bubble_single: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> in_ready);

  // R8: latched policy holds while the pipeline is occupied
  a_r8_policy_held: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_empty |=> (pipe_empty || $stable(pol_q)));
endmodule

// File: rtl/wbs_stage_pipe.sv
module wbs_stage_pipe
  import wbs_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int NSTG  = NUM_STG
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       issue_fire,
  input  logic                       issue_load,
  input  logic                       issue_short,
  input  logic [TAG_W-1:0]           issue_tag,
  output logic [NSTG-1:0]            vld_o,
  output logic [NSTG-1:0]            load_o,
  output logic [NSTG-1:0]            short_o,
  output logic [NSTG-1:0][TAG_W-1:0] tag_o
);
  logic [NSTG-1:0]            vld_q, vld_d;
  logic [NSTG-1:0]            load_q, load_d;
  logic [NSTG-1:0]            short_q, short_d;
  logic [NSTG-1:0]            upd_en;
  logic [NSTG-1:0][TAG_W-1:0] tag_q, tag_d;

  for (genvar i = 0; i < NSTG; i++) begin : g_stg
    if (i == STG_IF) begin : g_head
      assign vld_d[i]   = issue_fire;
      assign load_d[i]  = issue_load;
      assign short_d[i] = issue_short;
      assign tag_d[i]   = issue_tag;
    end else begin : g_body
      // a short op retires out of the memory slot and is not passed on
      localparam bit DROP_SHORT = (i == STG_WB);
      assign vld_d[i]   = vld_q[i-1] & ~(DROP_SHORT & short_q[i-1]);
      assign load_d[i]  = load_q[i-1];
      assign short_d[i] = short_q[i-1];
      assign tag_d[i]   = tag_q[i-1];
    end
    assign upd_en[i] = vld_d[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // payload flops: enabled, not reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < NSTG; i++) begin
      if (upd_en[i]) begin
        tag_q[i]   <= tag_d[i];
        load_q[i]  <= load_d[i];
        short_q[i] <= short_d[i];
      end
    end
  end

  assign vld_o   = vld_q;
  assign load_o  = load_q;
  assign short_o = short_q;
  assign tag_o   = tag_q;

  for (genvar i = 0; i < NSTG - 1; i++) begin : g_chk
    localparam bit AT_MEM = (i == STG_MEM);
    // R2: occupied stage moves forward with its tag
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q[i] && !(AT_MEM && short_q[i])) |=> (vld_q[i+1] && tag_q[i+1] == $past(tag_q[i])));
    if (AT_MEM) begin : g_mem
      // R4: short op leaves after the memory slot
      a_r4_short_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q[i] && short_q[i]) |=> !vld_q[i+1]);
    end
  end
endmodule

// File: rtl/wbs_wb_select.sv
module wbs_wb_select
  import wbs_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int NSTG  = NUM_STG
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSTG-1:0]            vld_i,
  input  logic [NSTG-1:0]            short_i,
  input  logic [NSTG-1:0][TAG_W-1:0] tag_i,
  output logic                       wb_en,
  output logic [TAG_W-1:0]           wb_tag,
  output logic                       err_o
);
  logic short_wb, full_wb;
  logic err_q, err_d;

  always_comb begin
    short_wb = vld_i[STG_MEM] && short_i[STG_MEM];
    full_wb  = vld_i[STG_WB];
    wb_en    = short_wb || full_wb;
    wb_tag   = full_wb ? tag_i[STG_WB] : tag_i[STG_MEM];
    err_d    = err_q || (short_wb && full_wb);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err_o = err_q;

  // R7: the two retirement slots never fire together
  a_r7_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(short_wb && full_wb));

  // R7: error flag is sticky
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/wbs_counters.sv
module wbs_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire_i,
  input  logic             bubble_i,
  output logic [CNT_W-1:0] cyc_o,
  output logic [CNT_W-1:0] ret_o,
  output logic [CNT_W-1:0] bub_o
);
  logic [CNT_W-1:0] cyc_q, cyc_d, ret_q, ret_d, bub_q, bub_d;

  always_comb begin
    cyc_d = cyc_q + CNT_W'(1);
    ret_d = ret_q + CNT_W'(1);
    bub_d = bub_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      ret_q <= '0;
      bub_q <= '0;
    end else begin
      cyc_q <= cyc_d;
      if (retire_i) ret_q <= ret_d;
      if (bubble_i) bub_q <= bub_d;
    end
  end

  assign cyc_o = cyc_q;
  assign ret_o = ret_q;
  assign bub_o = bub_q;

  // R9: cycle counter steps every clock
  a_r9_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cyc_q == $past(cyc_q) + CNT_W'(1)));

  // R9: bubble counter idle without a withheld slot
  a_r9_bubble_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(bubble_i)) |-> $stable(bub_q));
endmodule

// File: rtl/wb_port_sched.sv
module wb_port_sched
  import wbs_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int CNT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_i,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic                     in_is_load,
  input  logic [TAG_W-1:0]         in_tag,
  output logic                     wb_en,
  output logic [TAG_W-1:0]         wb_tag,
  output logic                     wb_collide_err,
  output logic [NUM_STG-1:0]       stage_valid,
  output logic [NUM_STG*TAG_W-1:0] stage_tags,
  output logic [CNT_W-1:0]         cnt_cycles,
  output logic [CNT_W-1:0]         cnt_retired,
  output logic [CNT_W-1:0]         cnt_bubbles
);
  logic                          issue_fire, issue_short, bubble;
  logic [NUM_STG-1:0]            vld, load, short_op;
  logic [NUM_STG-1:0][TAG_W-1:0] tags;

  wbs_issue_ctrl u_issue (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .pipe_empty (~|vld),
    .s0_vld     (vld[STG_IF]),
    .s0_load    (load[STG_IF]),
    .in_valid   (in_valid),
    .in_is_load (in_is_load),
    .in_ready   (in_ready),
    .issue_fire (issue_fire),
    .issue_short(issue_short),
    .bubble     (bubble)
  );

  wbs_stage_pipe #(.TAG_W(TAG_W), .NSTG(NUM_STG)) u_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_fire (issue_fire),
    .issue_load (in_is_load),
    .issue_short(issue_short),
    .issue_tag  (in_tag),
    .vld_o      (vld),
    .load_o     (load),
    .short_o    (short_op),
    .tag_o      (tags)
  );

  wbs_wb_select #(.TAG_W(TAG_W), .NSTG(NUM_STG)) u_wb (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (vld),
    .short_i(short_op),
    .tag_i  (tags),
    .wb_en  (wb_en),
    .wb_tag (wb_tag),
    .err_o  (wb_collide_err)
  );

  wbs_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .retire_i(wb_en),
    .bubble_i(bubble),
    .cyc_o   (cnt_cycles),
    .ret_o   (cnt_retired),
    .bub_o   (cnt_bubbles)
  );

  assign stage_valid = vld;
  assign stage_tags  = tags;

  // R3: a load strobes its own tag five cycles after acceptance
  a_r3_load_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_is_load) |-> ##5 (wb_en && wb_tag == $past(in_tag, 5)));
endmodule

// File: tb/wb_port_sched_tb.sv
module wb_port_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 8;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mode_i, in_valid, in_is_load;
  logic [TW-1:0] in_tag;
  logic          in_ready, wb_en, wb_collide_err;
  logic [TW-1:0] wb_tag;
  logic [4:0]    stage_valid;
  logic [5*TW-1:0] stage_tags;
  logic [CW-1:0] cnt_cycles, cnt_retired, cnt_bubbles;

  always #(CLK_PERIOD/2) clk = ~clk;

  wb_port_sched #(.TAG_W(TW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .in_valid(in_valid),
    .in_ready(in_ready), .in_is_load(in_is_load), .in_tag(in_tag),
    .wb_en(wb_en), .wb_tag(wb_tag), .wb_collide_err(wb_collide_err),
    .stage_valid(stage_valid), .stage_tags(stage_tags),
    .cnt_cycles(cnt_cycles), .cnt_retired(cnt_retired), .cnt_bubbles(cnt_bubbles)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model state
  int cyc = 0;
  int max_w = -1;
  int ent_a [8];
  int ent_w [8];
  logic [TW-1:0] ent_tag [8];
  bit ent_ld [8];
  int wp = 0;
  bit mode_hold = 0;
  int ret_cnt = 0;
  int bub_cnt = 0;
  bit last_acc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int w_of(input int a, input bit ld, input bit pol);
    return a + ((ld || pol) ? 4 : 3);
  endfunction

  // one clock: drive, check against the model, advance
  task automatic step(input bit v, input bit ld, input logic [TW-1:0] tg, input bit md);
    bit empty, meff, s0_load, exp_wb, rdy_exp, acc;
    logic [TW-1:0] exp_tag;
    logic [4:0] exp_sv;
    logic [5*TW-1:0] exp_st, mask;
    in_valid = v; in_is_load = ld; in_tag = tg; mode_i = md;
    #1;
    empty = (cyc > max_w);
    meff = empty ? md : mode_hold;
    s0_load = 0; exp_wb = 0; exp_tag = '0; exp_sv = '0; exp_st = '0; mask = '0;
    for (int k = 0; k < 8; k++) begin
      if (ent_a[k] <= cyc && cyc <= ent_w[k]) begin
        int s;
        s = cyc - ent_a[k];
        exp_sv[s] = 1'b1;
        exp_st[s*TW +: TW] = ent_tag[k];
        mask[s*TW +: TW] = '1;
        if (s == 0 && ent_ld[k]) s0_load = 1;
        if (cyc == ent_w[k]) begin exp_wb = 1; exp_tag = ent_tag[k]; end
      end
    end
    rdy_exp = !(s0_load && !ld && !meff);
    chk(in_ready == rdy_exp, "R5 R6 R8", "in_ready", in_ready, rdy_exp);
    chk(wb_en == exp_wb, "R3 R4 R6 R7", "wb_en", wb_en, exp_wb);
    if (exp_wb) chk(wb_tag == exp_tag, "R3 R4", "wb_tag", wb_tag, exp_tag);
    chk(stage_valid == exp_sv, "R2 R4 R6", "stage_valid", stage_valid, exp_sv);
    chk((stage_tags & mask) == exp_st, "R2", "stage_tags", stage_tags & mask, exp_st);
    chk(cnt_cycles == CW'(cyc), "R9", "cnt_cycles", cnt_cycles, cyc);
    chk(cnt_retired == CW'(ret_cnt), "R9", "cnt_retired", cnt_retired, ret_cnt);
    chk(cnt_bubbles == CW'(bub_cnt), "R9", "cnt_bubbles", cnt_bubbles, bub_cnt);
    chk(wb_collide_err == 1'b0, "R7", "wb_collide_err", wb_collide_err, 0);
    ret_cnt += exp_wb;
    bub_cnt += (v && !rdy_exp);
    mode_hold = meff;
    acc = v && rdy_exp;
    if (acc) begin
      ent_a[wp] = cyc + 1;
      ent_w[wp] = w_of(cyc + 1, ld, meff);
      ent_tag[wp] = tg;
      ent_ld[wp] = ld;
      if (ent_w[wp] > max_w) max_w = ent_w[wp];
      wp = (wp + 1) % 8;
    end
    last_acc = acc;
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  task automatic drain(input bit md);
    repeat (8) step(0, 0, '0, md);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] r0, b0;
    bit hold, md, rv, rld;
    logic [TW-1:0] rtag;
    void'($urandom(32'h5EED_0147));
    for (int k = 0; k < 8; k++) begin ent_a[k] = -100; ent_w[k] = -100; ent_tag[k] = '0; ent_ld[k] = 0; end
    rst_n = 1'b0; in_valid = 0; in_is_load = 0; in_tag = '0; mode_i = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(stage_valid == 5'b0, "R1", "stage_valid in reset", stage_valid, 0);
    chk(wb_en == 1'b0, "R1", "wb_en in reset", wb_en, 0);
    chk(wb_collide_err == 1'b0, "R1", "err in reset", wb_collide_err, 0);
    chk(cnt_cycles == 0 && cnt_retired == 0 && cnt_bubbles == 0, "R1", "counters in reset",
        cnt_cycles + cnt_retired + cnt_bubbles, 0);
    chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    cyc = 0;

    // R5 R4: load then register-type under bubble policy
    step(1, 1, 8'h11, 0);
    step(1, 0, 8'h12, 0);
    step(1, 0, 8'h12, 0);
    step(1, 0, 8'h13, 0);
    drain(0);

    // R8: policy change while occupied is ignored
    step(1, 1, 8'h21, 0);
    step(1, 0, 8'h22, 1);
    step(1, 0, 8'h22, 1);
    drain(1);

    // R6: padded policy, register-type right behind a load
    step(1, 1, 8'h31, 1);
    step(1, 0, 8'h32, 1);
    step(1, 1, 8'h33, 1);
    step(1, 0, 8'h34, 1);
    drain(1);

    // R10: padded throughput, one retirement per cycle once full
    r0 = '0; b0 = cnt_bubbles;
    for (int i = 0; i < 30; i++) begin
      if (i == 10) r0 = cnt_retired;
      step(1, i[0], 8'(8'h40 + i), 1);
    end
    chk(cnt_retired - r0 == CW'(20), "R10", "padded retirements over 20 cycles", cnt_retired - r0, 20);
    chk(cnt_bubbles == b0, "R10", "padded bubbles", cnt_bubbles, b0);
    drain(0);

    // R10: alternating stream under bubble policy costs one bubble per pair
    b0 = cnt_bubbles;
    for (int p = 0; p < 10; p++) begin
      step(1, 1, 8'(8'h80 + 2*p), 0);
      step(1, 0, 8'(8'h81 + 2*p), 0);
      step(1, 0, 8'(8'h81 + 2*p), 0);
    end
    chk(cnt_bubbles - b0 == CW'(10), "R10", "bubbles for 10 pairs", cnt_bubbles - b0, 10);
    drain(0);

    // constrained random mix
    hold = 0; md = 0; rv = 0; rld = 0; rtag = '0;
    for (int n = 0; n < 1500; n++) begin
      if (!hold) begin
        rv = ($urandom % 4) != 0;
        rld = $urandom % 2;
        rtag = 8'($urandom);
      end
      if (($urandom % 16) == 0) md = ~md;
      step(rv, rld, rtag, md);
      hold = rv && !last_acc;
    end
    drain(md);

    done = 1;
    summary();
    $finish;
  end
endmodule